// File: doc/BRIEF.md
# Glitchless pin-selected frequency switcher

This block drives eight divided clocks from one source clock. Six of the outputs are switchable. Each holds two preset half-period values, one for setting 1 and one for setting 2. Two asynchronous frequency-select pins choose between those values. A pair of six-bit link masks connects each pin to any subset of the six switchable outputs. The last two outputs each run from one fixed half-period value, and no pin reaches them.

A change on a linked pin never cuts a clock phase short. The pin first passes through a two-flop synchroniser. The affected divider then finishes its current high phase and its current low phase at the old value. It loads the new value on the edge where the output rises again, so the new frequency starts with its own leading edge. Only the level that the synchronised pin has at that boundary matters. A toggle that reverts before the boundary leaves no trace.

Top module: `freq_switch_bank`

## Requirements
- R1: Reset is synchronous and active high. While it is held and just after, every output is low, with its phase counter at zero and setting 1 in force. After release, output i first rises on the H-th rising clock edge, where H is its active half-period.
- R2: Each output is a square wave that is high for H source cycles and low for H source cycles, where H is its active half-period value. A value of 0 is treated as 1.
- R3: For a switchable output linked to a pin, a synchronised pin level of 0 selects half_f1 and a level of 1 selects half_f2.
- R4: Bit i of link_mask[p] links pin freq_sel[p] to switchable output i. Any subset of outputs may be linked to either pin.
- R5: A switchable output whose mask bits are all 0 stays on half_f1, whatever the pin levels.
- R6: When more than one pin is linked to an output, the lowest-numbered linked pin alone controls it.
- R7: Outputs 6 and 7 run at half_fixed[0] and half_fixed[1] and do not respond to the pins.
- R8: A new half-period value takes effect only at the end of a low phase. Every phase has the length of either the old value or the new value, and the first phase at the new value is a high phase.
- R9: A pin pulse that returns to its old level before the next low-phase end has no effect on the output.
- R10: After a pin change, the first high phase at the new value starts within 2*H_old+2 source cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | NPIN | Asynchronous frequency-select pins |
| link_mask | input | NPIN x NSW | Per-pin mask; bit i links that pin to switchable output i |
| half_f1 | input | NSW x HALF_W | Setting 1 half-period value for each switchable output |
| half_f2 | input | NSW x HALF_W | Setting 2 half-period value for each switchable output |
| half_fixed | input | NFIX x HALF_W | Half-period value for each fixed output |
| clk_out | output | NSW+NFIX | Divided clocks; switchable outputs first, then fixed outputs |

## Verification
Each divider holds a phase counter, a level and a latched half-period value. An error in any of them shows at the port within one output period: a phase of the wrong length, or a phase that matches neither the old value nor the new one. A wrong routing or priority decision shows as a whole output settling at the other setting, about two cycles plus one old period after the pin moves. The bench measures the lengths of the high and low runs on every output. Around a switch it logs each run of one output, so runt phases, a late latch and a swallowed pulse can all be seen directly.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    localparam int HALF_W   = 8;
    localparam int DEF_NSW  = 6;
    localparam int DEF_NFIX = 2;
    localparam int DEF_NPIN = 2;

    typedef logic [HALF_W-1:0] half_t;

    // State carried by one divider
    typedef struct packed {
        half_t cnt;   // position inside the current phase
        half_t hact;  // half-period value in force
        logic  lvl;   // output level
    } div_state_t;

    // A zero half-period value runs as one cycle per phase
    function automatic half_t clamp_half(input half_t h);
        return (h == '0) ? half_t'(1) : h;
    endfunction

endpackage

// File: rtl/fsw_sync.sv
module fsw_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/fsw_route.sv
module fsw_route #(
    parameter int NPIN = 2,
    parameter int NSW  = 6
) (
    input  logic [NPIN-1:0][NSW-1:0] link,
    input  logic [NPIN-1:0]          pin_s,
    output logic [NSW-1:0]           sel
);
    // The pins are visited from highest to lowest so that the lowest linked pin writes last
    always_comb begin
        for (int i = 0; i < NSW; i++) begin
            sel[i] = 1'b0;
            for (int p = NPIN - 1; p >= 0; p--) begin
                if (link[p][i]) sel[i] = pin_s[p];
            end
        end
    end
endmodule

// File: rtl/fsw_div.sv
module fsw_div
    import fsw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  half_t half_next,
    output logic  clk_o
);
    div_state_t st;
    half_t      tgt;
    logic       wrap;

    assign tgt   = clamp_half(half_next);
    assign wrap  = (st.cnt == st.hact - half_t'(1));
    assign clk_o = st.lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cnt  <= '0;
            st.lvl  <= 1'b0;
            st.hact <= tgt;
        end else if (wrap) begin
            st.cnt <= '0;
            st.lvl <= ~st.lvl;
            // The new value is taken only as a low phase ends, so it starts with a rising edge
            if (!st.lvl) st.hact <= tgt;
        end else begin
            st.cnt <= st.cnt + half_t'(1);
        end
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        st.cnt < st.hact);

    assert_half_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        st.hact != '0);

    assert_switch_at_rise_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(st.hact) |-> $rose(st.lvl));
endmodule

// File: rtl/freq_switch_bank.sv
module freq_switch_bank
    import fsw_pkg::*;
#(
    parameter int NSW  = DEF_NSW,
    parameter int NFIX = DEF_NFIX,
    parameter int NPIN = DEF_NPIN
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPIN-1:0]              freq_sel,
    input  logic [NPIN-1:0][NSW-1:0]     link_mask,
    input  logic [NSW-1:0][HALF_W-1:0]   half_f1,
    input  logic [NSW-1:0][HALF_W-1:0]   half_f2,
    input  logic [NFIX-1:0][HALF_W-1:0]  half_fixed,
    output logic [NSW+NFIX-1:0]          clk_out
);
    logic [NPIN-1:0] pin_s;
    logic [NSW-1:0]  sel_eff;

    fsw_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (freq_sel),
        .dout(pin_s)
    );

    fsw_route #(.NPIN(NPIN), .NSW(NSW)) u_route (
        .link (link_mask),
        .pin_s(pin_s),
        .sel  (sel_eff)
    );

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        half_t           nxt;
        logic [NPIN-1:0] col;

        assign nxt = sel_eff[i] ? half_f2[i] : half_f1[i];

        for (genvar p = 0; p < NPIN; p++) begin : g_col
            assign col[p] = link_mask[p][i];
        end

        fsw_div u_div (
            .clk      (clk),
            .rst      (rst),
            .half_next(nxt),
            .clk_o    (clk_out[i])
        );

        assert_unlinked_R5: assert property (@(posedge clk) disable iff (rst)
            (col == '0) |-> !sel_eff[i]);

        assert_low_pin_R6: assert property (@(posedge clk) disable iff (rst)
            col[0] |-> (sel_eff[i] == pin_s[0]));
    end

    for (genvar j = 0; j < NFIX; j++) begin : g_fix
        fsw_div u_div (
            .clk      (clk),
            .rst      (rst),
            .half_next(half_fixed[j]),
            .clk_o    (clk_out[NSW+j])
        );
    end
endmodule

// File: tb/sim_freq_switch_bank.sv
`timescale 1ns/1ps
module sim_freq_switch_bank;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      freq_sel = '0;
    logic [1:0][5:0] link_mask = '0;
    logic [5:0][7:0] half_f1;
    logic [5:0][7:0] half_f2;
    logic [1:0][7:0] half_fixed;
    logic [7:0]      clk_out;

    always #5 clk = ~clk;

    freq_switch_bank u0 (
        .clk(clk), .rst(rst), .freq_sel(freq_sel), .link_mask(link_mask),
        .half_f1(half_f1), .half_f2(half_f2), .half_fixed(half_fixed),
        .clk_out(clk_out)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run-length monitor sampled on the falling edge
    int   cyc = 0;
    int   run[8];
    int   hi_len[8];
    int   lo_len[8];
    logic last[8];
    bit   log_en = 0;
    int   nlog = 0;
    int   log_len[64];
    logic log_lvl[64];
    int   log_start[64];

    initial begin
        for (int i = 0; i < 8; i++) begin
            run[i] = 0; hi_len[i] = 0; lo_len[i] = 0; last[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < 8; i++) begin
            if (clk_out[i] == last[i]) begin
                run[i]++;
            end else begin
                if (last[i]) hi_len[i] = run[i];
                else lo_len[i] = run[i];
                if (i == 0 && log_en && nlog < 64) begin
                    log_len[nlog]   = run[i];
                    log_lvl[nlog]   = last[i];
                    log_start[nlog] = cyc - run[i];
                    nlog++;
                end
                run[i]  = 1;
                last[i] = clk_out[i];
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    typedef struct packed {
        logic [5:0] m0;
        logic [5:0] m1;
        logic [1:0] pins;
        logic [5:0] exps;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'b000000, 6'b000000, 2'b11, 6'b000000},
        '{6'b101001, 6'b010110, 2'b01, 6'b101001},
        '{6'b101001, 6'b010110, 2'b10, 6'b010110},
        '{6'b101001, 6'b010110, 2'b11, 6'b111111},
        '{6'b111111, 6'b111111, 2'b10, 6'b000000},
        '{6'b000000, 6'b111111, 2'b10, 6'b111111},
        '{6'b000011, 6'b111100, 2'b01, 6'b000011},
        '{6'b001100, 6'b001111, 2'b10, 6'b000011}
    };

    initial begin
        #1_000_000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int t0;
        int first_new;
        int ok;
        for (int i = 0; i < 6; i++) begin
            half_f1[i] = 8'(2 + i);
            half_f2[i] = 8'(8 + i);
        end
        half_fixed[0] = 8'd4;
        half_fixed[1] = 8'd9;

        // R1: reset state and first rising edge
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(1);
        chk("R1 all low after reset", int'(clk_out), 0);
        wait_cyc(1);
        chk("R1 out0 rises on 2nd edge", int'(clk_out[0]), 1);
        chk("R1 out1 still low", int'(clk_out[1]), 0);

        // Table walk: R3, R4, R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            link_mask[0] = VECS[v].m0;
            link_mask[1] = VECS[v].m1;
            freq_sel     = VECS[v].pins;
            wait_cyc(120);
            for (int i = 0; i < 6; i++) begin
                int h;
                h = VECS[v].exps[i] ? (8 + i) : (2 + i);
                chk($sformatf("R3/R4/R5/R6 vec%0d out%0d hi*100+lo", v, i),
                    hi_len[i] * 100 + lo_len[i], h * 101);
            end
            chk($sformatf("R7 vec%0d out6", v), hi_len[6] * 100 + lo_len[6], 404);
            chk($sformatf("R7 vec%0d out7", v), hi_len[7] * 100 + lo_len[7], 909);
        end

        // R2: a zero value runs as one cycle per phase
        link_mask = '0;
        freq_sel  = '0;
        half_f1[0] = 8'd0;
        wait_cyc(60);
        chk("R2 zero clamp out0", hi_len[0] * 100 + lo_len[0], 101);

        // R8, R10: glitchless switch 3 -> 5 on output 0
        half_f1[0] = 8'd3;
        half_f2[0] = 8'd5;
        link_mask[0] = 6'b000001;
        wait_cyc(60);
        nlog = 0;
        log_en = 1;
        wait_cyc(13);
        t0 = cyc;
        freq_sel[0] = 1'b1;
        wait_cyc(60);
        log_en = 0;
        ok = 1;
        first_new = -1;
        for (int k = 1; k < nlog; k++) begin
            if (log_len[k] != 3 && log_len[k] != 5) ok = 0;
            if (first_new < 0 && log_len[k] == 5) first_new = k;
            if (first_new >= 0 && log_len[k] != 5) ok = 0;
        end
        chk("R8 no runt phase around switch", ok, 1);
        chk("R8 switch happened", int'(first_new > 0), 1);
        if (first_new > 0) begin
            chk("R8 first new phase is high", int'(log_lvl[first_new]), 1);
            chk("R10 switch latency bound", int'((log_start[first_new] - t0) <= 8), 1);
        end

        // R9: a short pulse that reverts before the boundary is swallowed
        freq_sel[0] = 1'b0;
        half_f1[0] = 8'd10;
        half_f2[0] = 8'd2;
        wait_cyc(80);
        nlog = 0;
        log_en = 1;
        @(posedge clk_out[0]);
        wait_cyc(2);
        freq_sel[0] = 1'b1;
        wait_cyc(4);
        freq_sel[0] = 1'b0;
        wait_cyc(80);
        log_en = 0;
        ok = (nlog > 3) ? 1 : 0;
        for (int k = 1; k < nlog; k++) begin
            if (log_len[k] != 10) ok = 0;
        end
        chk("R9 pending pulse overwritten", ok, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule